// File: doc/BRIEF.md
# Phase-Shifted Twin PWM Generator

The block produces two pulse-width modulated outputs that share one period. The second output rises a fixed number of ticks after the first one. Both waveforms come from a single free-running 16-bit counter. The counter advances on each cycle in which `tick` is high, so a prescaler outside the block sets the time base. In the intended setting that prescaler turns 1 MHz into 125 kHz. With a 48000-tick period this gives 384 ms, with output 0 high for two thirds of it, output 1 starting a sixth of a period later and output 1 high for a quarter of it.

The counter is never reset at a period boundary. Each channel keeps its own compare value and a two-state action: rise, then fall.
- On a rise match, the channel records the match point. It then re-arms its compare one high-width later.
- On a fall match, it re-arms at the recorded rise point plus the period.

As a result, the phase offset between the channels can take any value from zero to a full period. Period and widths are held in shadow inputs and take effect at the next rise of output 0. The delay is captured only while the block is disabled.

Top module: `dual_phase_pwm`

## Requirements
- R1: While `en` is low, one cycle later both outputs and both strobes are 0, the counter is at zero and both channels wait for a rise. After reset everything is 0.
- R2: While `en` is high, ticks are numbered from 0, starting at the first enabled cycle with `tick` high. Output 0 first rises in the cycle after tick START (default 2). Cycles without a tick change nothing.
- R3: Both outputs repeat with the period T (`period_i`, 1 to 65535 ticks).
- R4: Output 1 rises D ticks after every rise of output 0, where D is `delay_i`. D = 0 makes both rise on the same tick, and D = T places output 1's rise on output 0's next rise.
- R5: In each period, output 0 is high for W0 ticks and output 1 for W1 ticks. The two widths are independent.
- R6: A width of 0 keeps its output low. A width of T or more keeps it high without any low cycle.
- R7: All compare arithmetic wraps modulo 2^16, so timing stays exact when the counter rolls over during long periods.
- R8: New `period_i`, `width0_i` and `width1_i` values take effect on output 0's next rise tick, and that rise already uses them. Output 1 picks them up at its following rise. A pulse of output 1 that is in progress keeps its old width.
- R9: `delay_i` is captured only while `en` is low. Changing it while the block runs has no effect.
- R10: A delay larger than T behaves as a delay of exactly T.
- R11: While enabled, an output changes only in a cycle in which that channel's strobe is high.
- R12: A strobe is high for exactly one cycle after each tick on which its channel's compare matches. This covers both rise and fall actions, and also the rise action of a zero-width or full-width channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance enable |
| en | input | 1 | Run enable; low clears and re-arms |
| period_i | input | 16 | Period T in ticks |
| width0_i | input | 16 | High width of output 0 |
| delay_i | input | 16 | Delay D of output 1 behind output 0 |
| width1_i | input | 16 | High width of output 1 |
| pwm0_o | output | 1 | PWM output 0 |
| pwm1_o | output | 1 | PWM output 1 |
| hit0_o | output | 1 | Compare-match strobe of channel 0 |
| hit1_o | output | 1 | Compare-match strobe of channel 1 |

## Verification
The sensitive coincidence is a rise of output 0, which also loads the shadow values, landing on the same tick as an action of channel 1. This happens with a zero delay, a delay equal to the period, or a channel 1 pulse that straddles output 0's rise while new values arrive. A sweep of every width and delay against a six-tick period, including over-range values, provokes these coincidences. Directed update runs also change the period and widths just before such a tick. Each run is judged tick by tick against the rise and fall times the bench computes arithmetically, with the waveform split into an old and a new segment at output 0's first rise after the update.

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm #(
  parameter int CW    = 16,
  parameter int START = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] width0_i,
  input  logic [CW-1:0] delay_i,
  input  logic [CW-1:0] width1_i,
  output logic          pwm0_o,
  output logic          pwm1_o,
  output logic          hit0_o,
  output logic          hit1_o
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cmp   [2];
  logic [CW-1:0] rise  [2];
  logic [CW-1:0] tsv   [2];
  logic [CW-1:0] act_w [2];
  logic [CW-1:0] win   [2];
  logic [CW-1:0] eff_w [2];
  logic [CW-1:0] act_t, eff_t, d_clamp;
  logic [1:0]    falling, match, out, hit;
  logic          upd;

  assign win[0]  = width0_i;
  assign win[1]  = width1_i;
  assign match[0] = tick && (cnt == cmp[0]);
  assign match[1] = tick && (cnt == cmp[1]);
  assign upd      = match[0] && !falling[0];
  assign eff_t    = upd ? period_i : act_t;
  assign eff_w[0] = upd ? width0_i : act_w[0];
  assign eff_w[1] = upd ? width1_i : act_w[1];
  assign d_clamp  = (delay_i > period_i) ? period_i : delay_i;

  assign pwm0_o = out[0];
  assign pwm1_o = out[1];
  assign hit0_o = hit[0];
  assign hit1_o = hit[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_t   <= '0;
      falling <= '0;
      out     <= '0;
      hit     <= '0;
      for (int i = 0; i < 2; i++) begin
        cmp[i]   <= '0;
        rise[i]  <= '0;
        tsv[i]   <= '0;
        act_w[i] <= '0;
      end
    end else if (!en) begin
      cnt     <= '0;
      act_t   <= period_i;
      falling <= '0;
      out     <= '0;
      hit     <= '0;
      cmp[0]  <= CW'(START);
      cmp[1]  <= CW'(START) + d_clamp;
      for (int i = 0; i < 2; i++) begin
        rise[i]  <= '0;
        tsv[i]   <= '0;
        act_w[i] <= win[i];
      end
    end else begin
      hit <= match;
      if (tick) cnt <= cnt + 1'b1;
      if (upd) begin
        act_t    <= period_i;
        act_w[0] <= width0_i;
        act_w[1] <= width1_i;
      end
      for (int i = 0; i < 2; i++) begin
        if (match[i]) begin
          if (!falling[i]) begin
            rise[i] <= cnt;
            tsv[i]  <= eff_t;
            if (eff_w[i] == '0) begin
              out[i] <= 1'b0;
              cmp[i] <= cmp[i] + eff_t;
            end else if (eff_w[i] >= eff_t) begin
              out[i] <= 1'b1;
              cmp[i] <= cmp[i] + eff_t;
            end else begin
              out[i]     <= 1'b1;
              cmp[i]     <= cmp[i] + eff_w[i];
              falling[i] <= 1'b1;
            end
          end else begin
            out[i]     <= 1'b0;
            cmp[i]     <= rise[i] + tsv[i];
            falling[i] <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dual_phase_pwm_chk.sv
module dual_phase_pwm_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic en,
  input logic pwm0_o,
  input logic pwm1_o,
  input logic hit0_o,
  input logic hit1_o
);

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm0_o && !pwm1_o && !hit0_o && !hit1_o));

  p_edge_strobe0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$stable(pwm0_o)) |-> hit0_o);

  p_edge_strobe1_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$stable(pwm1_o)) |-> hit1_o);

  p_strobe_tick0_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit0_o |-> ($past(tick) && $past(en)));

  p_strobe_tick1_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit1_o |-> ($past(tick) && $past(en)));

endmodule

bind dual_phase_pwm dual_phase_pwm_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .en(en),
  .pwm0_o(pwm0_o), .pwm1_o(pwm1_o), .hit0_o(hit0_o), .hit1_o(hit1_o)
);

// File: tb/test_dual_phase_pwm.sv
module test_dual_phase_pwm;
  localparam int ST = 2;
  localparam int NEVER = 1 << 30;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, en = 1'b0;
  logic [15:0] period_i = '0, width0_i = '0, delay_i = '0, width1_i = '0;
  logic pwm0_o, pwm1_o, hit0_o, hit1_o;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  dual_phase_pwm i_dual_phase_pwm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en),
    .period_i(period_i), .width0_i(width0_i), .delay_i(delay_i), .width1_i(width1_i),
    .pwm0_o(pwm0_o), .pwm1_o(pwm1_o), .hit0_o(hit0_o), .hit1_o(hit1_o)
  );

  function automatic bit lvl(int k, int base, int t, int w);
    int wc;
    if (k < base) return 1'b0;
    wc = (w > t) ? t : w;
    return ((k - base) % t) < wc;
  endfunction

  function automatic bit evt(int k, int base, int t, int w);
    int wc, r;
    if (k < base) return 1'b0;
    wc = (w > t) ? t : w;
    r  = (k - base) % t;
    return (r == 0) || (wc > 0 && wc < t && r == wc);
  endfunction

  task automatic chk(bit ok, string req, string what, int k, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s at tick %0d: got %0d expected %0d", req, what, k, act, exp);
    end
  endtask

  task automatic run(int ta, int w0a, int da, int w1a, int nt, int gap,
                     int kc, int tb, int w0b, int db, int w1b, string req);
    int dc, r0, b1, k, cyc;
    int nbad [4];
    int fk [4];
    int fa [4];
    int fe [4];
    bit tk;
    bit [3:0] got, exp;
    string nm [4];
    nm[0] = "pwm0"; nm[1] = "pwm1"; nm[2] = "hit0"; nm[3] = "hit1";
    for (int i = 0; i < 4; i++) begin nbad[i] = 0; fk[i] = 0; fa[i] = 0; fe[i] = 0; end
    @(negedge clk);
    en = 1'b0; tick = 1'b0;
    period_i = 16'(ta); width0_i = 16'(w0a); delay_i = 16'(da); width1_i = 16'(w1a);
    repeat (2) @(posedge clk);
    @(negedge clk);
    dc = (da > ta) ? ta : da;
    r0 = NEVER;
    b1 = NEVER;
    if (kc >= 0) begin
      r0 = ST;
      while (r0 < kc) r0 += ta;
      b1 = r0 + ((dc == ta) ? 0 : dc);
    end
    k = -1; cyc = 0;
    en = 1'b1;
    while (k < nt - 1) begin
      tk = ((cyc % (gap + 1)) == 0);
      if (tk && kc >= 0 && k + 1 == kc) begin
        period_i = 16'(tb); width0_i = 16'(w0b); delay_i = 16'(db); width1_i = 16'(w1b);
      end
      tick = tk;
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (tk) k++;
      exp[0] = (k < 0) ? 1'b0 : (k < r0) ? lvl(k, ST, ta, w0a) : lvl(k, r0, tb, w0b);
      exp[1] = (k < 0) ? 1'b0 : (k < b1) ? lvl(k, ST + dc, ta, w1a) : lvl(k, b1, tb, w1b);
      exp[2] = tk && ((k < r0) ? evt(k, ST, ta, w0a) : evt(k, r0, tb, w0b));
      exp[3] = tk && ((k < b1) ? evt(k, ST + dc, ta, w1a) : evt(k, b1, tb, w1b));
      got = {hit1_o, hit0_o, pwm1_o, pwm0_o};
      for (int i = 0; i < 4; i++)
        if (got[i] !== exp[i]) begin
          if (nbad[i] == 0) begin fk[i] = k; fa[i] = int'(got[i]); fe[i] = int'(exp[i]); end
          nbad[i]++;
        end
    end
    tick = 1'b0;
    for (int i = 0; i < 4; i++) chk(nbad[i] == 0, req, nm[i], fk[i], fa[i], fe[i]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({pwm0_o, pwm1_o, hit0_o, hit1_o} == 4'b0, "R1", "reset outputs", 0,
        int'({pwm0_o, pwm1_o, hit0_o, hit1_o}), 0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R10: every width and delay, including over-range, at T=6
    for (int w0 = 0; w0 <= 7; w0++)
      for (int d = 0; d <= 7; d++)
        for (int w1 = 0; w1 <= 7; w1++)
          run(6, w0, d, w1, 26, 0, -1, 0, 0, 0, 0, "R2 R3 R4 R5 R6 R10");

    // R6: single-tick period, full and empty
    run(1, 1, 1, 0, 8, 0, -1, 0, 0, 0, 0, "R6");

    // R12 R2: sparse ticks, strobes one cycle and levels hold between ticks
    run(5, 2, 3, 4, 20, 2, -1, 0, 0, 0, 0, "R12");

    // R8 R9: shrink period, full-width output 1, delay change ignored
    run(8, 3, 2, 4, 40, 0, 13, 5, 1, 4, 5, "R8 R9");
    // R8: delay equal to period, update coincides with channel 1 rise
    run(6, 2, 6, 3, 40, 0, 12, 9, 4, 1, 2, "R8 R4");
    // R8: channel 1 pulse straddles the update rise, period grows
    run(6, 2, 3, 5, 40, 1, 9, 10, 7, 0, 3, "R8 R9");

    // R7: reference setting across counter rollover, then R1 on disable
    run(48000, 32000, 8000, 12000, 70000, 0, -1, 0, 0, 0, 0, "R7");
    run(6, 6, 0, 6, 10, 0, -1, 0, 0, 0, 0, "R6");
    @(negedge clk);
    chk(pwm0_o && pwm1_o, "R6", "held high before disable", 0, int'({pwm0_o, pwm1_o}), 3);
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({pwm0_o, pwm1_o, hit0_o, hit1_o} == 4'b0, "R1", "disable clears", 0,
        int'({pwm0_o, pwm1_o, hit0_o, hit1_o}), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule